// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a two-way set-associative data cache that sits between a CPU load/store port and a slower lower-level memory. Each block is 32 bytes and each set holds two blocks. Every block carries a tag, a valid bit and a dirty bit, and every set carries one bit that records which way was used last. Loads that hit return a word one cycle after they are accepted. Stores that hit take two cycles: the tag is checked first, and the bytes are written into the matching way in the next cycle.

On a miss the cache evicts the way that was not used last. If that way holds modified data, the cache first sends the whole block out on the writeback channel. It then requests the missing block on the fill channel. When the fill arrives the cache installs the block and replays the request, which then hits. Store misses allocate in the same way, and the store's enabled bytes are merged into the fetched block. The CPU port accepts one request at a time, and `req_ready` stays low from acceptance until the response.

The parameter `SETS` sets the number of sets. The index width and tag width are derived from it.

Top module: `wb_cache2w`

## Requirements
- R1: The byte address is split into three parts: bits [4:0] select a byte within the 32-byte block, the next log2(SETS) bits select the set, and all remaining upper bits form the tag. A fill request always carries a block-aligned address (bits [4:0] zero).
- R2: A request hits only when one way of its set has its valid bit set and a stored tag equal to the request tag. Otherwise it misses and raises exactly one fill.
- R3: Each set records its most recently used way. That record is updated on every hit and on every fill. A miss replaces the way that is not the most recently used one, so two blocks that map to the same set can both stay resident.
- R4: A load hit asserts `resp_valid` with the addressed 32-bit word in the first cycle after acceptance, and it causes no fill or writeback.
- R5: A store hit completes in two cycles: a tag-check cycle, then a write cycle in which `resp_valid` is asserted. Only the bytes enabled by `req_be` (bit n covers bits 8n+7:8n of the word) are written, and only in the matching way. The other way of the set keeps its data.
- R6: A miss whose victim is invalid or clean causes a single fill and no writeback.
- R7: A miss whose victim is valid and dirty first writes the victim block back, at address {victim tag, index, 00000}. The fill follows, and the two requests are never raised together.
- R8: A store miss is write-allocate: the block is fetched, the enabled bytes are merged into it, and the block becomes dirty. Bytes that are not enabled keep the value they had in memory.
- R9: Reset clears every valid bit, dirty bit and most-recently-used bit. After reset `req_ready` is high, and `resp_valid`, `fill_req` and `wb_req` are low.
- R10: `req_ready` is low from acceptance until the response. `resp_valid` is a single-cycle pulse, given once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| req_ready | output | 1 | Cache can accept a request |
| resp_valid | output | 1 | Load data valid or store done |
| resp_rdata | output | 32 | Load data |
| fill_req | output | 1 | Block fill request |
| fill_addr | output | 32 | Block-aligned fill address |
| fill_ack | input | 1 | Fill data present this cycle |
| fill_data | input | 256 | Fill block, word 0 in low bits |
| wb_req | output | 1 | Block writeback request |
| wb_addr | output | 32 | Block-aligned writeback address |
| wb_data | output | 256 | Writeback block |
| wb_ack | input | 1 | Writeback accepted this cycle |

## Verification
The bench targets several corner cases, and each one shows a distinct symptom when the design is wrong:
- **Three tags in one set.** A cache that picked the wrong victim would evict the block just touched, producing an extra fill on the next access.
- **Dirty victim.** A design that dropped the writeback or sent it to the wrong address would later return stale data for that block.
- **Partial byte enables on a store miss.** A broken merge would corrupt the neighbouring bytes.
- **Store into one way while the other way holds data.** A write steered to the wrong way would show up when the untouched block is read back.
- **Hit latencies and absence of memory traffic on hits.** These are checked against a behavioural model of tags and use order.

// File: rtl/wb_cache2w.sv
module wb_cache2w #(
  parameter int SETS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [31:0]  req_addr,
  input  logic [31:0]  req_wdata,
  input  logic [3:0]   req_be,
  output logic         req_ready,
  output logic         resp_valid,
  output logic [31:0]  resp_rdata,
  output logic         fill_req,
  output logic [31:0]  fill_addr,
  input  logic         fill_ack,
  input  logic [255:0] fill_data,
  output logic         wb_req,
  output logic [31:0]  wb_addr,
  output logic [255:0] wb_data,
  input  logic         wb_ack
);
  localparam int IW = $clog2(SETS);
  localparam int TW = 32 - 5 - IW;

  typedef enum logic [2:0] {IDLE, LOOK, STW, WBK, FIL} st_t;
  st_t st;

  logic [TW-1:0]  tags [2][SETS];
  logic [255:0]   blks [2][SETS];
  logic [SETS-1:0] vld [2];
  logic [SETS-1:0] drt [2];
  logic [SETS-1:0] mru;

  logic        q_write;
  logic [31:0] q_addr;
  logic [31:0] q_wdata;
  logic [3:0]  q_be;
  logic        sway;

  logic [IW-1:0] idx;
  logic [TW-1:0] tg;
  logic [2:0]    wsel;
  logic          hit0, hit1, hit, hway, victim;
  logic [255:0]  merged;

  assign idx    = q_addr[5 +: IW];
  assign tg     = q_addr[31 -: TW];
  assign wsel   = q_addr[4:2];
  assign hit0   = vld[0][idx] && (tags[0][idx] == tg);
  assign hit1   = vld[1][idx] && (tags[1][idx] == tg);
  assign hit    = hit0 | hit1;
  assign hway   = hit1;
  assign victim = ~mru[idx];

  assign req_ready  = (st == IDLE);
  assign resp_valid = (st == LOOK && hit && !q_write) || (st == STW);
  assign resp_rdata = blks[hway][idx][32*wsel +: 32];
  assign fill_req   = (st == FIL);
  assign fill_addr  = {q_addr[31:5], 5'b0};
  assign wb_req     = (st == WBK);
  assign wb_addr    = {tags[victim][idx], idx, 5'b0};
  assign wb_data    = blks[victim][idx];

  always_comb begin
    merged = blks[sway][idx];
    for (int b = 0; b < 4; b++)
      if (q_be[b]) merged[32*wsel + 8*b +: 8] = q_wdata[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      vld[0] <= '0;
      vld[1] <= '0;
      drt[0] <= '0;
      drt[1] <= '0;
      mru    <= '0;
      sway   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) st <= LOOK;
        LOOK: begin
          if (hit) begin
            mru[idx] <= hway;
            sway     <= hway;
            st       <= q_write ? STW : IDLE;
          end else if (vld[victim][idx] && drt[victim][idx]) begin
            st <= WBK;
          end else begin
            st <= FIL;
          end
        end
        STW: begin
          drt[sway][idx] <= 1'b1;
          st             <= IDLE;
        end
        WBK: if (wb_ack) st <= FIL;
        FIL: if (fill_ack) begin
          vld[victim][idx] <= 1'b1;
          drt[victim][idx] <= 1'b0;
          mru[idx]         <= victim;
          st               <= LOOK;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == IDLE && req_valid) begin
      q_write <= req_write;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
      q_be    <= req_be;
    end
    if (st == STW) blks[sway][idx] <= merged;
    if (st == FIL && fill_ack) begin
      blks[victim][idx] <= fill_data;
      tags[victim][idx] <= tg;
    end
  end
endmodule

// File: rtl/chk_wb_cache2w.sv
module chk_wb_cache2w (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        fill_req,
  input logic [31:0] fill_addr,
  input logic        fill_ack,
  input logic        wb_req,
  input logic [31:0] wb_addr,
  input logic        wb_ack
);
  assert_fill_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> fill_addr[4:0] == 5'd0);
  assert_fill_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req && $stable(fill_addr));
  assert_fill_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_ack |=> !fill_req);
  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr));
  assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> fill_req);
  assert_one_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_req && fill_req));
  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_no_resp_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
endmodule

bind wb_cache2w chk_wb_cache2w u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .fill_req(fill_req), .fill_addr(fill_addr),
  .fill_ack(fill_ack), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
);

// File: tb/tb_wb_cache2w.sv
module tb_wb_cache2w;
  localparam int SETS = 16;
  localparam int IW = $clog2(SETS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_be = 0;
  logic req_ready, resp_valid, fill_req, wb_req;
  logic [31:0] resp_rdata, fill_addr, wb_addr;
  logic fill_ack = 0, wb_ack = 0;
  logic [255:0] fill_data = '0;
  logic [255:0] wb_data;

  wb_cache2w #(.SETS(SETS)) dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, fills = 0, wbs = 0, fcnt = 0, wcnt = 0;
  bit expecting = 0;
  logic [31:0] last_wb = 0;
  logic [31:0] lower  [bit [31:0]];
  logic [31:0] golden [bit [31:0]];
  int unsigned mtag [SETS][2];
  bit mv [SETS][2];
  bit md [SETS][2];
  int mmru [SETS];

  function automatic logic [31:0] seed_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction
  function automatic logic [31:0] lower_rd(logic [31:0] a);
    return lower.exists(a) ? lower[a] : seed_word(a);
  endfunction
  function automatic logic [31:0] gold_rd(logic [31:0] a);
    return golden.exists(a) ? golden[a] : seed_word(a);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // lower-level memory responder
  always @(negedge clk) begin
    if (fill_ack) begin
      fill_ack = 0; fcnt = 0;
    end else if (fill_req) begin
      fcnt++;
      if (fcnt == 3) begin
        for (int w = 0; w < 8; w++) fill_data[32*w +: 32] = lower_rd(fill_addr + 4*w);
        fill_ack = 1; fills++;
      end
    end
    if (wb_ack) begin
      wb_ack = 0; wcnt = 0;
    end else if (wb_req) begin
      wcnt++;
      if (wcnt == 2) begin
        for (int w = 0; w < 8; w++) lower[wb_addr + 4*w] = wb_data[32*w +: 32];
        last_wb = wb_addr; wbs++; wb_ack = 1;
      end
    end
  end

  // every-clock protocol comparison
  always @(negedge clk) if (rst_n) begin
    if (resp_valid && !expecting) chk(0, "R10", "response without pending request", 1, 0);
    if (fill_req && wb_req) chk(0, "R7", "fill and writeback together", 1, 0);
  end

  task automatic access(bit wr, logic [31:0] a, logic [31:0] wd, logic [3:0] be, string req);
    int idx, hw, lat, f0, w0, vic;
    int unsigned tg;
    bit expwb;
    logic [31:0] expwa, waddr, g;
    idx = int'((a >> 5) % SETS);
    tg = a >> (5 + IW);
    waddr = {a[31:2], 2'b00};
    hw = -1; expwb = 0; expwa = 0;
    for (int w = 0; w < 2; w++) if (mv[idx][w] && mtag[idx][w] == tg) hw = w;
    if (hw >= 0) begin
      mmru[idx] = hw;
      if (wr) md[idx][hw] = 1;
    end else begin
      vic = 1 - mmru[idx];
      expwb = mv[idx][vic] && md[idx][vic];
      expwa = (mtag[idx][vic] << (5 + IW)) | (idx << 5);
      mtag[idx][vic] = tg; mv[idx][vic] = 1; md[idx][vic] = wr; mmru[idx] = vic;
    end
    f0 = fills; w0 = wbs;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    expecting = 1;
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!resp_valid && lat < 300) begin @(negedge clk); lat++; end
    chk(resp_valid == 1, req, "response arrived", resp_valid, 1);
    if (!wr) chk(resp_rdata == gold_rd(waddr), req, "load data", resp_rdata, gold_rd(waddr));
    if (hw >= 0) begin
      chk(lat == (wr ? 2 : 1), req, "hit latency", lat, wr ? 2 : 1);
      chk(fills == f0 && wbs == w0, req, "no traffic on hit", fills - f0 + wbs - w0, 0);
    end else begin
      chk(fills == f0 + 1, req, "one fill on miss", fills - f0, 1);
      chk(wbs == w0 + int'(expwb), req, "writeback count", wbs - w0, int'(expwb));
      if (expwb) chk(last_wb == expwa, req, "writeback address", last_wb, expwa);
    end
    if (wr) begin
      g = gold_rd(waddr);
      for (int b = 0; b < 4; b++) if (be[b]) g[8*b +: 8] = wd[8*b +: 8];
      golden[waddr] = g;
    end
    @(negedge clk);
    expecting = 0;
    chk(req_ready == 1, "R10", "ready after response", req_ready, 1);
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mmru[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; md[s][w] = 0; mtag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R9", "ready after reset", req_ready, 1);
    chk(!resp_valid && !fill_req && !wb_req, "R9", "idle outputs after reset",
        {resp_valid, fill_req, wb_req}, 0);
    // cold miss, then hit in the same block
    access(0, 32'h0000_0040, 0, 0, "R2");
    access(0, 32'h0000_0044, 0, 0, "R4");
    // conflicting tag in the same set: both stay resident
    access(0, 32'h0000_1040, 0, 0, "R6");
    access(0, 32'h0000_0048, 0, 0, "R3");
    access(0, 32'h0000_1050, 0, 0, "R3");
    // store hit, then touch the other way
    access(1, 32'h0000_1048, 32'hCAFE_F00D, 4'hF, "R5");
    access(0, 32'h0000_004C, 0, 0, "R5");
    // third tag evicts the dirty non-MRU block
    access(0, 32'h0000_2040, 0, 0, "R7");
    access(0, 32'h0000_1048, 0, 0, "R7");
    // partial store miss (write-allocate), then read it back
    access(1, 32'h0000_00A4, 32'h1122_3344, 4'b0101, "R8");
    access(0, 32'h0000_00A4, 0, 0, "R8");
    // store one way, other way of the set unchanged
    access(1, 32'h0000_204C, 32'hDEAD_BEEF, 4'b1000, "R5");
    access(0, 32'h0000_104C, 0, 0, "R5");
    access(0, 32'h0000_204C, 0, 0, "R5");
    // last set boundary
    access(1, 32'h0000_01E0, 32'h0BAD_CAFE, 4'hF, "R1");
    access(0, 32'hFFFF_FFFC, 0, 0, "R1");
    access(0, 32'h0000_01E0, 0, 0, "R1");
    // mixed traffic over four tags and three sets
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = ($urandom % 4) << (5 + IW) | (($urandom % 3) + 3) << 5 | ($urandom % 8) << 2;
      access($urandom % 2, a, $urandom, 4'($urandom % 16), "R1");
    end
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule